// File: doc/BRIEF.md
# Prioritized Interrupt Level Encoder

This block sits between a set of board-level interrupt sources and a processor that takes a single encoded interrupt-level input. Each of thirteen level-sensitive request lines is captured into its own bit of a sixteen-bit monitor register. The bit positions are fixed and not contiguous. A software-written enable mask gates that register. From the pending requests that remain, the block picks the most urgent one and presents its level, inverted, on a four-bit output. A value of zero on that output means no request.

Software reaches the block through a small synchronous register window of 64 bytes, using an address, a write strobe, 16-bit write data and registered read data. The window holds the enable mask and a general-purpose output register whose value drives a set of pins. It also holds a fixed version word and a power-off register. Writing the power-off register with its lowest bit set emits a single-cycle shutdown request to the rest of the system.

Top module: `irq_level_encoder`

## Requirements
- R1: After reset the enable mask, monitor and output-port registers are zero. The level output, read data and shutdown request are all 0.
- R2: Source i has priority level i. Its monitor bit is: src0 bit 11, src1 bit 9, src2 bit 8, src3 bit 12, src4 bit 10, src5 bit 6, src6 bit 5, src7 bit 4, src8 bit 7, src9 bit 14, src10 bit 13, src11 bit 0, src12 bit 15. The monitor bit follows its input high and low.
- R3: A source is pending only while its input is high and its monitor bit is also set in the enable mask.
- R4: Among pending sources the lowest level wins. The level output carries the winning level XOR 15, and 0 when nothing is pending.
- R5: The level output is registered. It reflects an input change, or a mask write, on the first clock edge after it.
- R6: Offset 0x00 is the enable mask. A read returns the last value written there.
- R7: Offset 0x36 is the output-port register. It reads back the last value written, and the output-port pins carry the same value.
- R8: Offset 0x30 is the power-off register and always reads 0. A write with bit 0 set raises the shutdown request for exactly the next cycle. A write with bit 0 clear raises nothing.
- R9: Offset 0x32 always reads 0x0010, and writes to it have no effect.
- R10: Any other offset reads 0. A write there changes neither the mask, nor the output port, nor the level output.
- R11: Read data appears one cycle after the address is presented. It shows register contents from before any write made in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Byte offset within the register window |
| busWe | input | 1 | Write strobe, single-cycle |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Registered read data |
| irqIn | input | 13 | Level-sensitive request inputs, bit i is source i |
| irlOut | output | 4 | Encoded interrupt level (winning level XOR 15) |
| portOut | output | 16 | General output-port pins |
| shutdownReq | output | 1 | Single-cycle shutdown request |

## Verification
The embedded assertions check three things on every cycle. First, the level output always matches the encoding of the present monitor and mask state, and a nonzero level implies some enabled request. Second, a shutdown pulse is always caused by a qualifying power-off write. Third, reads of the version offset and of unlisted offsets return their fixed values. Only the bench scenarios can show that the source-to-bit mapping and the priority order are right. It sweeps every single source, every pair of sources and every masked-off source, plus pseudo-random input and mask mixes. The scenarios also cover register read-back, the one-cycle timing and the fact that writes to read-only and unlisted offsets are ignored.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;

  localparam int NUM_SRC = 13;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 6;
  localparam int LVL_W   = 4;
  localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'((1 << LVL_W) - 1);

  localparam logic [ADDR_W-1:0] OFF_MASK = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_PWR  = 6'h30;
  localparam logic [ADDR_W-1:0] OFF_VER  = 6'h32;
  localparam logic [ADDR_W-1:0] OFF_PORT = 6'h36;
  localparam logic [DATA_W-1:0] VERSION_WORD = 16'h0010;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_MASK = 2'd1,
    RD_PORT = 2'd2,
    RD_VER  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   maskWe;
    logic   portWe;
    logic   pwrOff;
    rdSel_e rdSel;
  } ctrlStrobe_t;

  // monitor bit position of each source; level of source i is i
  function automatic int srcBit(input int idx);
    case (idx)
      0:  srcBit = 11;
      1:  srcBit = 9;
      2:  srcBit = 8;
      3:  srcBit = 12;
      4:  srcBit = 10;
      5:  srcBit = 6;
      6:  srcBit = 5;
      7:  srcBit = 4;
      8:  srcBit = 7;
      9:  srcBit = 14;
      10: srcBit = 13;
      11: srcBit = 0;
      default: srcBit = 15;
    endcase
  endfunction

  // lowest pending level, inverted so that idle encodes as zero
  function automatic logic [LVL_W-1:0] encodeLevel(input logic [DATA_W-1:0] pend);
    logic [LVL_W-1:0] lvl;
    lvl = IDLE_LVL;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[srcBit(i)]) lvl = LVL_W'(i);
    end
    encodeLevel = lvl ^ IDLE_LVL;
  endfunction

endpackage

// File: rtl/irq_enc_ctrl.sv
module irq_enc_ctrl
  import irq_enc_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              wrBit0,
  output ctrlStrobe_t       strb
);

  always_comb begin
    strb.maskWe = busWe && (busAddr == OFF_MASK);
    strb.portWe = busWe && (busAddr == OFF_PORT);
    strb.pwrOff = busWe && (busAddr == OFF_PWR) && wrBit0;
    case (busAddr)
      OFF_MASK: strb.rdSel = RD_MASK;
      OFF_PORT: strb.rdSel = RD_PORT;
      OFF_VER:  strb.rdSel = RD_VER;
      default:  strb.rdSel = RD_ZERO;
    endcase
  end

endmodule

// File: rtl/irq_enc_datapath.sv
module irq_enc_datapath
  import irq_enc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [DATA_W-1:0]  rdData,
  output logic [LVL_W-1:0]   levelOut,
  output logic [DATA_W-1:0]  portOut,
  output logic               shutdownReq
);

  logic [DATA_W-1:0] monReg;
  logic [DATA_W-1:0] maskReg;
  logic [DATA_W-1:0] monNext;
  logic [DATA_W-1:0] maskNext;

  // scatter the request lines onto their monitor bit positions
  always_comb begin
    monNext = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      monNext[srcBit(i)] = irqIn[i];
    end
  end

  assign maskNext = strb.maskWe ? wrData : maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      monReg      <= '0;
      maskReg     <= '0;
      portOut     <= '0;
      levelOut    <= '0;
      shutdownReq <= 1'b0;
      rdData      <= '0;
    end else begin
      monReg      <= monNext;
      maskReg     <= maskNext;
      if (strb.portWe) portOut <= wrData;
      levelOut    <= encodeLevel(monNext & maskNext);
      shutdownReq <= strb.pwrOff;
      case (strb.rdSel)
        RD_MASK: rdData <= maskReg;
        RD_PORT: rdData <= portOut;
        RD_VER:  rdData <= VERSION_WORD;
        default: rdData <= '0;
      endcase
    end
  end

  // R4: registered level always agrees with the stored monitor and mask
  a_r4_level_tracks_state: assert property (@(posedge clk) disable iff (!rstN)
    levelOut == encodeLevel(monReg & maskReg));

  // R3: a nonzero level needs at least one enabled, asserted source
  a_r3_level_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (levelOut != '0) |-> ((monReg & maskReg) != '0));

endmodule

// File: rtl/irq_level_encoder.sv
module irq_level_encoder
  import irq_enc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [LVL_W-1:0]   irlOut,
  output logic [DATA_W-1:0]  portOut,
  output logic               shutdownReq
);

  ctrlStrobe_t strb;

  irq_enc_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .wrBit0  (busWrData[0]),
    .strb    (strb)
  );

  irq_enc_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (busWrData),
    .irqIn       (irqIn),
    .rdData      (busRdData),
    .levelOut    (irlOut),
    .portOut     (portOut),
    .shutdownReq (shutdownReq)
  );

  // R8: every shutdown pulse comes from a power-off write with bit 0 set
  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> $past(busWe && (busAddr == OFF_PWR) && busWrData[0]));

  // R9: version offset always reads its fixed word
  a_r9_version_read: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busAddr) == OFF_VER) |-> (busRdData == VERSION_WORD));

  // R10: unlisted offsets read zero (power-off also reads zero, R8)
  a_r10_unlisted_zero: assert property (@(posedge clk) disable iff (!rstN)
    (($past(busAddr) != OFF_MASK) && ($past(busAddr) != OFF_PORT) &&
     ($past(busAddr) != OFF_VER)) |-> (busRdData == '0));

endmodule

// File: tb/irq_level_encoder_tb.sv
module irq_level_encoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [12:0] irqIn = '0;
  logic [3:0]  irlOut;
  logic [15:0] portOut;
  logic        shutdownReq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] lfsr = 32'h1234_5678;
  logic [15:0] curMask = '0;

  always #10 clk = ~clk;

  irq_level_encoder u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWrData(busWrData), .busRdData(busRdData), .irqIn(irqIn),
    .irlOut(irlOut), .portOut(portOut), .shutdownReq(shutdownReq)
  );

  function automatic int bitOf(input int s);
    int t [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
    return t[s];
  endfunction

  function automatic logic [3:0] expLevel(input logic [12:0] req, input logic [15:0] msk);
    for (int s = 0; s < 13; s++) begin
      if (req[s] && msk[bitOf(s)]) return 4'(s) ^ 4'hF;
    end
    return 4'h0;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWrData = d;
    if (a == 6'h00) curMask = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic doRead(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    @(negedge clk);
    d = busRdData;
  endtask

  task automatic setReq(input logic [12:0] v);
    @(negedge clk);
    irqIn = v;
    @(negedge clk);
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 level", 16'(irlOut), 16'h0);
    check("R1 shutdown", 16'(shutdownReq), 16'h0);
    check("R1 rddata", busRdData, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 port", portOut, 16'h0);
    doRead(6'h00, rd); check("R1 mask", rd, 16'h0);
    // R3 input alone with mask clear is not pending
    setReq(13'h1FFF); check("R3 mask clear", 16'(irlOut), 16'h0);
    // R5 mask write updates level on the next edge
    doWrite(6'h00, 16'hFFFF); check("R5 mask write", 16'(irlOut), 16'hF);
    setReq('0); check("R4 idle", 16'(irlOut), 16'h0);
    // R2 each source alone
    for (int s = 0; s < 13; s++) begin
      setReq(13'(1) << s);
      check($sformatf("R2 src%0d", s), 16'(irlOut), 16'(4'(s) ^ 4'hF));
    end
    // R4 every pair: lower level wins
    for (int a = 0; a < 13; a++) begin
      for (int b = a + 1; b < 13; b++) begin
        setReq((13'(1) << a) | (13'(1) << b));
        check($sformatf("R4 pair %0d,%0d", a, b), 16'(irlOut), 16'(4'(a) ^ 4'hF));
      end
    end
    // R3 each source masked off while all requests high
    for (int s = 0; s < 13; s++) begin
      doWrite(6'h00, ~(16'(1) << bitOf(s)));
      setReq(13'h1FFF);
      check($sformatf("R3 masked src%0d", s), 16'(irlOut), 16'(expLevel(13'h1FFF, curMask)));
    end
    // R5 timing: just after input change, before the edge, old value holds
    doWrite(6'h00, 16'hFFFF);
    setReq('0);
    @(negedge clk); irqIn = 13'h0010;
    #1 check("R5 before edge", 16'(irlOut), 16'h0);
    @(negedge clk); check("R5 after edge", 16'(irlOut), 16'(4'd4 ^ 4'hF));
    // R2 monitor bit clears when input drops
    setReq('0); check("R2 deassert", 16'(irlOut), 16'h0);
    // pseudo-random requests and masks
    for (int n = 0; n < 150; n++) begin
      lfsr = nextRand(lfsr);
      if (n % 5 == 0) doWrite(6'h00, lfsr[31:16]);
      setReq(lfsr[12:0]);
      check("R4 random", 16'(irlOut), 16'(expLevel(lfsr[12:0], curMask)));
    end
    // R6 mask read back
    doWrite(6'h00, 16'hA5C3); doRead(6'h00, rd); check("R6 readback", rd, 16'hA5C3);
    // R7 output port
    doWrite(6'h36, 16'h3C5A); doRead(6'h36, rd); check("R7 readback", rd, 16'h3C5A);
    check("R7 pins", portOut, 16'h3C5A);
    // R8 power-off
    doRead(6'h30, rd); check("R8 read zero", rd, 16'h0);
    doWrite(6'h30, 16'h0001); check("R8 pulse", 16'(shutdownReq), 16'h1);
    @(negedge clk); check("R8 one cycle", 16'(shutdownReq), 16'h0);
    doWrite(6'h30, 16'hFFFE); check("R8 bit0 clear", 16'(shutdownReq), 16'h0);
    // R9 version
    doWrite(6'h32, 16'hBEEF); doRead(6'h32, rd); check("R9 version", rd, 16'h0010);
    doRead(6'h00, rd); check("R9 mask untouched", rd, 16'hA5C3);
    // R10 unlisted offsets
    setReq(13'h1FFF);
    for (int a = 2; a < 64; a += 6) begin
      if (a == 6'h30 || a == 6'h32 || a == 6'h36) continue;
      doWrite(6'(a), 16'h0000);
      doRead(6'(a), rd); check($sformatf("R10 read %0h", a), rd, 16'h0);
    end
    check("R10 level held", 16'(irlOut), 16'(expLevel(13'h1FFF, 16'hA5C3)));
    check("R10 port held", portOut, 16'h3C5A);
    // R11 read in same cycle as write returns old contents
    @(negedge clk);
    busAddr = 6'h36; busWe = 1'b1; busWrData = 16'h1111;
    @(negedge clk);
    busWe = 1'b0;
    check("R11 old data", busRdData, 16'h3C5A);
    @(negedge clk); check("R11 new data", busRdData, 16'h1111);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule